// File: doc/BRIEF.md
# Asynchronous Strobe-Acknowledge Bus Responder

This block is a memory-mapped target on a bus that runs without a shared clock. The master signals a transfer with active-low strobes: an address strobe, a data strobe, an output enable for reads and a write enable for writes. A direction line and a two-bit size code go with them. The responder passes the strobes through a synchronizer. It checks whether the address falls inside its window and works out which byte lanes take part from the size code and the two low address bits. After a programmable number of delay clocks it either returns bytes from a small internal register file or stores the bytes offered by the master. It then asserts a two-bit active-low acknowledge whose encoding reports the port width.

The acknowledge and any read data stay asserted until the responder sees one of the strobes negated. The first strobe to drop ends the cycle, and both outputs are released shortly afterwards, so a stale acknowledge cannot leak into the next transfer. The tristate data bus is modelled as a data-out vector plus one output enable per byte lane. The delay input lets a test system force the master to insert wait states.

Top module: `async_slave_resp`

## Requirements
- R1: While reset is active and right after it, `dack_n` is 2'b11, `lane_oe` is 4'b0000 and `data_out` is zero.
- R2: Lane k covers `data_out`/`data_in` bits [31-8k:24-8k] and is flagged by `lane_oe[k]`. The size code `siz` is 01 = one byte, 10 = two bytes, 11 = three bytes, 00 = four bytes. On the default 32-bit port, the enabled lanes run from lane `addr[1:0]` upward, with as many lanes as the size asks for, and stop at lane 3.
- R3: On a read acknowledge, each enabled lane k carries the stored byte at byte address (port group base + k) of the addressed word, where byte 0 of a word is lane 0. Lanes that are not enabled drive zero with their enable low, and no lane is enabled while `dack_n` is 2'b11.
- R4: A write (`rd_wr`=0 with `as_n`, `ds_n` and `we_n` low) stores the enabled lanes of `data_in` at the edge where the acknowledge is asserted. Other bytes of the word keep their value, and `lane_oe` stays 4'b0000 during the write.
- R5: The asserted acknowledge is 2'b00 for a 32-bit port, 2'b01 for a 16-bit port and 2'b10 for an 8-bit port, selected by `PORT_W`.
- R6: If the start strobes are first sampled asserted at clock edge N, the acknowledge and read data appear after edge N+3+`resp_delay`.
- R7: Acknowledge, lane enables and data hold steady until the first negation among `as_n`, `ds_n` and the direction's enable (`oe_n` for reads, `we_n` for writes). If that negation is first sampled at edge M, all three outputs return to their idle values after edge M+2.
- R8: After a cycle ends, no new cycle starts until both `as_n` and `ds_n` have been seen high. Dropping and reasserting `ds_n` alone while `as_n` stays low produces no second acknowledge.
- R9: An address whose bits above the word index differ from `BASE_ADDR` gets no acknowledge and writes nothing.
- R10: If a strobe is negated during the delay window, the cycle is abandoned with no acknowledge and no write.
- R11: A read with `oe_n` high, or a write with `we_n` high, is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_delay | input | DLY_W | Delay clocks before acknowledge, sampled at cycle start |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| oe_n | input | 1 | Read output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| rd_wr | input | 1 | Direction, 1 = read, 0 = write |
| siz | input | 2 | Transfer size code |
| addr | input | AW | Byte address |
| data_in | input | 32 | Write data from master, lane 0 in the top byte |
| data_out | output | 32 | Read data toward master |
| lane_oe | output | 4 | Per-lane output enable for `data_out` |
| dack_n | output | 2 | Active-low acknowledge, encodes port width |

## Verification
The main function is tried with every size code at different low-address offsets, including offsets where the requested size runs past the end of the long word. This separates the lane-truncation rule from a plain size decode. A byte write into an already filled word, followed by a long read, shows whether lane steering on the write side disturbs neighbouring bytes. The cycle-ending behaviour is driven in several ways: all strobes dropping together, only the output enable dropping, and only the data strobe dropping while the address strobe stays low. These show that release follows the first negation and that a new cycle needs a full strobe idle. Zero and non-zero delays separate the fixed synchronizer latency from the programmable wait, and a strobe that drops inside the delay window shows that an abandoned write leaves the word unchanged.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ACK   = 2'd2,
    ST_RECOV = 2'd3
  } asr_state_e;

  localparam logic [1:0] SIZ_LONG   = 2'b00;
  localparam logic [1:0] SIZ_BYTE   = 2'b01;
  localparam logic [1:0] SIZ_WORD   = 2'b10;
  localparam logic [1:0] SIZ_TRIPLE = 2'b11;

  localparam logic [1:0] ACK_IDLE = 2'b11;

  // number of bytes requested by a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] siz);
    logic [2:0] n;
    case (siz)
      SIZ_BYTE:   n = 3'd1;
      SIZ_WORD:   n = 3'd2;
      SIZ_TRIPLE: n = 3'd3;
      default:    n = 3'd4;
    endcase
    return n;
  endfunction

  // acknowledge pattern that reports the port width
  function automatic logic [1:0] ack_code(input int port_w);
    logic [1:0] c;
    case (port_w)
      32:      c = 2'b00;
      16:      c = 2'b01;
      default: c = 2'b10;
    endcase
    return c;
  endfunction

  // lanes that exist on a port of the given width
  function automatic logic [3:0] port_lanes(input int port_w);
    logic [3:0] m;
    case (port_w)
      32:      m = 4'b1111;
      16:      m = 4'b0011;
      default: m = 4'b0001;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int   W       = 4,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{{W{RST_VAL}}}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/asr_lane_dec.sv
module asr_lane_dec
  import asr_pkg::*;
#(
  parameter int PORT_W = 32
) (
  input  logic [1:0] addr_lo,
  input  logic [1:0] siz,
  output logic [3:0] lane_en,
  output logic [1:0] grp_base
);

  localparam int         PB     = PORT_W / 8;
  localparam logic [1:0] IN_GRP = 2'(PB - 1);

  logic [2:0] first_lane;
  logic [2:0] n_bytes;
  logic [2:0] end_lane;

  assign grp_base   = addr_lo & ~IN_GRP;
  assign first_lane = {1'b0, addr_lo & IN_GRP};
  assign n_bytes    = size_bytes(siz);
  assign end_lane   = first_lane + n_bytes;

  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_lane
      if (k < PB) begin : g_present
        assign lane_en[k] = (3'(k) >= first_lane) && (3'(k) < end_lane);
      end else begin : g_absent
        assign lane_en[k] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/asr_regfile.sv
module asr_regfile #(
  parameter int NWORDS = 8,
  parameter int IDXW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [3:0]      wr_be,
  input  logic [31:0]     wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_data
);

  logic [NWORDS-1:0][31:0] words;

  genvar w;
  generate
    for (w = 0; w < NWORDS; w++) begin : g_word
      logic        word_we;
      logic [31:0] word_q;

      assign word_we = wr_en && (wr_idx == IDXW'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (word_we) begin
          for (int b = 0; b < 4; b++) begin
            if (wr_be[b]) begin
              word_q[31-8*b -: 8] <= wr_data[31-8*b -: 8];
            end
          end
        end
      end

      assign words[w] = word_q;
    end
  endgenerate

  assign rd_data = words[rd_idx];

endmodule

// File: rtl/asr_ctrl.sv
module asr_ctrl
  import asr_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rel,
  input  logic             bus_idle,
  input  logic [DLY_W-1:0] dly,
  output logic             load,
  output logic             ack_go,
  output logic             ack_drop
);

  asr_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    load     = 1'b0;
    ack_go   = 1'b0;
    ack_drop = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_WAIT;
          cnt_d   = dly;
          cnt_en  = 1'b1;
          load    = 1'b1;
        end
      end
      ST_WAIT: begin
        if (rel) begin
          state_d = ST_RECOV;
        end else if (cnt_q == '0) begin
          state_d = ST_ACK;
          ack_go  = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_ACK: begin
        if (rel) begin
          state_d  = ST_RECOV;
          ack_drop = 1'b1;
        end
      end
      ST_RECOV: begin
        if (bus_idle) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/async_slave_resp.sv
module async_slave_resp
  import asr_pkg::*;
#(
  parameter int            PORT_W      = 32,
  parameter int            AW          = 16,
  parameter int            NWORDS      = 8,
  parameter int            DLY_W       = 4,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] BASE_ADDR   = 16'h4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] resp_delay,
  input  logic             as_n,
  input  logic             ds_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             rd_wr,
  input  logic [1:0]       siz,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      data_in,
  output logic [31:0]      data_out,
  output logic [3:0]       lane_oe,
  output logic [1:0]       dack_n
);

  localparam int         IDXW   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int         TAGLSB = IDXW + 2;
  localparam logic [1:0] ACK_ON = ack_code(PORT_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       irst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign irst_n = rst_pipe_q[1];

  // strobe synchronizer
  logic [3:0] strb_s;
  logic       as_on, ds_on, oe_on, we_on;

  asr_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (irst_n),
    .d     ({we_n, oe_n, ds_n, as_n}),
    .q     (strb_s)
  );

  assign as_on = ~strb_s[0];
  assign ds_on = ~strb_s[1];
  assign oe_on = ~strb_s[2];
  assign we_on = ~strb_s[3];

  // address window and lane decode
  logic            hit;
  logic [3:0]      lane_raw;
  logic [1:0]      grp_raw;
  logic [IDXW-1:0] idx_raw;

  assign hit     = (addr[AW-1:TAGLSB] == BASE_ADDR[AW-1:TAGLSB]);
  assign idx_raw = addr[TAGLSB-1:2];

  asr_lane_dec #(
    .PORT_W (PORT_W)
  ) u_lane (
    .addr_lo  (addr[1:0]),
    .siz      (siz),
    .lane_en  (lane_raw),
    .grp_base (grp_raw)
  );

  // cycle captured at start
  logic            rd_q;
  logic [3:0]      lane_q;
  logic [1:0]      grp_q;
  logic [IDXW-1:0] idx_q;
  logic            start, rel, bus_idle;
  logic            load, ack_go, ack_drop;

  assign start    = as_on & ds_on & hit & (rd_wr ? oe_on : we_on);
  assign rel      = ~as_on | ~ds_on | ~(rd_q ? oe_on : we_on);
  assign bus_idle = ~as_on & ~ds_on;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      rd_q   <= 1'b1;
      lane_q <= '0;
      grp_q  <= '0;
      idx_q  <= '0;
    end else if (load) begin
      rd_q   <= rd_wr;
      lane_q <= lane_raw;
      grp_q  <= grp_raw;
      idx_q  <= idx_raw;
    end
  end

  asr_ctrl #(
    .DLY_W (DLY_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (irst_n),
    .start    (start),
    .rel      (rel),
    .bus_idle (bus_idle),
    .dly      (resp_delay),
    .load     (load),
    .ack_go   (ack_go),
    .ack_drop (ack_drop)
  );

  // storage with lane-to-byte steering
  logic [31:0] rd_word;
  logic [3:0]  wr_be;
  logic [31:0] wr_word;
  logic [31:0] rd_lanes;
  logic [31:0] lane_bits;

  assign wr_be    = lane_q << grp_q;
  assign wr_word  = data_in >> (8 * grp_q);
  assign rd_lanes = rd_word << (8 * grp_q);

  asr_regfile #(
    .NWORDS (NWORDS),
    .IDXW   (IDXW)
  ) u_rf (
    .clk     (clk),
    .rst_n   (irst_n),
    .wr_en   (ack_go & ~rd_q),
    .wr_idx  (idx_q),
    .wr_be   (wr_be),
    .wr_data (wr_word),
    .rd_idx  (idx_q),
    .rd_data (rd_word)
  );

  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_lbits
      assign lane_bits[31-8*k -: 8] = {8{lane_q[k]}};
    end
  endgenerate

  // registered bus outputs
  logic [1:0]  dack_q, dack_d;
  logic [3:0]  loe_q, loe_d;
  logic [31:0] dout_q, dout_d;
  logic        out_en;

  always_comb begin
    out_en = ack_go | ack_drop;
    dack_d = ACK_IDLE;
    loe_d  = '0;
    dout_d = '0;
    if (ack_go) begin
      dack_d = ACK_ON;
      if (rd_q) begin
        loe_d  = lane_q;
        dout_d = rd_lanes & lane_bits;
      end
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      dack_q <= ACK_IDLE;
      loe_q  <= '0;
      dout_q <= '0;
    end else if (out_en) begin
      dack_q <= dack_d;
      loe_q  <= loe_d;
      dout_q <= dout_d;
    end
  end

  assign dack_n   = dack_q;
  assign lane_oe  = loe_q;
  assign data_out = dout_q;

endmodule

// File: rtl/async_slave_resp_chk.sv
module async_slave_resp_chk
  import asr_pkg::*;
#(
  parameter int PORT_W = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  dack_n,
  input logic [3:0]  lane_oe,
  input logic [31:0] data_out,
  input logic        rel,
  input logic        rd_q
);

  localparam logic [1:0] ACK_ON = ack_code(PORT_W);
  localparam logic [3:0] LANES  = port_lanes(PORT_W);

  logic [31:0] oe_bits;
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      oe_bits[31-8*k -: 8] = {8{lane_oe[k]}};
    end
  end

  AST_ACK_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n != ACK_IDLE) |-> (dack_n == ACK_ON)); // R5

  AST_LANES_NEED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe != 4'b0000) |-> (dack_n != ACK_IDLE)); // R3

  AST_UNUSED_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_out & ~oe_bits) == 32'h0)); // R3

  AST_LANES_ON_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_oe & ~LANES) == 4'b0000)); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack_n != ACK_IDLE) && !rd_q) |-> (lane_oe == 4'b0000)); // R4

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack_n != ACK_IDLE) && !rel) |=>
      ($stable(dack_n) && $stable(lane_oe) && $stable(data_out))); // R7

  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack_n != ACK_IDLE) && rel) |=>
      ((dack_n == ACK_IDLE) && (lane_oe == 4'b0000))); // R7

endmodule

bind async_slave_resp async_slave_resp_chk #(
  .PORT_W (PORT_W)
) u_asr_chk (
  .clk      (clk),
  .rst_n    (irst_n),
  .dack_n   (dack_n),
  .lane_oe  (lane_oe),
  .data_out (data_out),
  .rel      (rel),
  .rd_q     (rd_q)
);

// File: tb/async_slave_resp_test.sv
module async_slave_resp_test;

  localparam int PORT_W = 32;
  localparam int PB     = PORT_W / 8;

  logic        clk;
  logic        rst_n;
  logic [3:0]  resp_delay;
  logic        as_n, ds_n, oe_n, we_n, rd_wr;
  logic [1:0]  siz;
  logic [15:0] addr;
  logic [31:0] data_in;
  logic [31:0] data_out;
  logic [3:0]  lane_oe;
  logic [1:0]  dack_n;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 0;
  bit finished = 0;

  async_slave_resp uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_delay (resp_delay),
    .as_n       (as_n),
    .ds_n       (ds_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .rd_wr      (rd_wr),
    .siz        (siz),
    .addr       (addr),
    .data_in    (data_in),
    .data_out   (data_out),
    .lane_oe    (lane_oe),
    .dack_n     (dack_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned mb [32];
  int          phase;      // 0 idle, 1 counting, 2 acknowledging, 3 awaiting idle bus
  int          left;
  int          rcnt;
  bit          m_rd;
  int          m_base;     // first byte address of the port group
  bit [3:0]    m_lanes;
  bit [3:0]    h_old, h_new; // strobe samples, two and one edges back
  logic [1:0]  e_dack;
  logic [3:0]  e_loe;
  logic [31:0] e_dout;

  always @(posedge clk) begin
    bit a_on, d_on, o_on, w_on, gone;
    int off, cnt;
    if (!rst_n) begin
      rcnt = 0; phase = 0; left = 0; m_rd = 1; m_base = 0; m_lanes = 0;
      h_old = 4'hF; h_new = 4'hF;
      e_dack = 2'b11; e_loe = 4'h0; e_dout = 32'h0;
      foreach (mb[i]) mb[i] = 8'h00;
    end else if (rcnt < 2) begin
      rcnt++;
      h_old = 4'hF; h_new = 4'hF;
    end else begin
      a_on = !h_old[0]; d_on = !h_old[1]; o_on = !h_old[2]; w_on = !h_old[3];
      gone = !a_on || !d_on || !(m_rd ? o_on : w_on);
      case (phase)
        0: if (a_on && d_on && (addr[15:5] == 11'h200) && (rd_wr ? o_on : w_on)) begin
             phase = 1; left = resp_delay; m_rd = rd_wr;
             off = addr[1:0] % PB;
             m_base = addr[4:2] * 4 + (addr[1:0] - off);
             cnt = (siz == 2'b00) ? 4 : siz;
             for (int k = 0; k < 4; k++) m_lanes[k] = (k < PB) && (k >= off) && (k < off + cnt);
           end
        1: if (gone) phase = 3;
           else if (left == 0) begin
             phase = 2; e_dack = 2'b00;
             for (int k = 0; k < 4; k++) if (m_lanes[k]) begin
               if (m_rd) begin
                 e_loe[k] = 1'b1;
                 e_dout[31-8*k -: 8] = mb[m_base + k];
               end else begin
                 mb[m_base + k] = data_in[31-8*k -: 8];
               end
             end
           end else left--;
        2: if (gone) begin phase = 3; e_dack = 2'b11; e_loe = 4'h0; e_dout = 32'h0; end
        default: if (!a_on && !d_on) phase = 0;
      endcase
      h_old = h_new;
      h_new = {we_n, oe_n, ds_n, as_n};
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check(dack_n === e_dack, "R6", "model acknowledge", {30'h0, dack_n}, {30'h0, e_dack});
      check(lane_oe === e_loe, "R2", "model lane enables", {28'h0, lane_oe}, {28'h0, e_loe});
      check(data_out === e_dout, "R3", "model read data", data_out, e_dout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle_bus();
    as_n = 1; ds_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic begin_cycle(input bit rd, input logic [15:0] a, input logic [1:0] sz,
                             input logic [31:0] wd, input int dly, input bit use_en,
                             input int limit, output bit acked, output int lat,
                             output logic [31:0] dv, output logic [3:0] lv);
    @(negedge clk);
    rd_wr = rd; addr = a; siz = sz; data_in = wd; resp_delay = 4'(dly);
    as_n = 0; ds_n = 0;
    if (use_en) begin
      if (rd) oe_n = 0; else we_n = 0;
    end
    acked = 0; lat = -1; dv = 'x; lv = 'x;
    for (int i = 0; i < limit && !acked; i++) begin
      @(negedge clk);
      if (dack_n != 2'b11) begin
        acked = 1; lat = i; dv = data_out; lv = lane_oe;
      end
    end
  endtask

  task automatic end_cycle(output int rl);
    idle_bus();
    rl = -1;
    for (int i = 0; i < 10 && rl < 0; i++) begin
      @(negedge clk);
      if (dack_n == 2'b11 && lane_oe == 4'h0) rl = i;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_rw(input bit rd, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input int dly, output bit acked,
                       output int lat, output logic [31:0] dv, output logic [3:0] lv,
                       output int rl);
    begin_cycle(rd, a, sz, wd, dly, 1'b1, 30, acked, lat, dv, lv);
    end_cycle(rl);
  endtask

  task automatic read_expect(input logic [15:0] a, input logic [1:0] sz,
                             input logic [31:0] exp_d, input logic [3:0] exp_l,
                             input string req);
    bit ak; int lat, rl; logic [31:0] dv; logic [3:0] lv;
    do_rw(1'b1, a, sz, 32'h0, 0, ak, lat, dv, lv, rl);
    check(ak, req, "read acknowledged", {31'h0, ak}, 32'h1);
    check(dv === exp_d, req, "read data", dv, exp_d);
    check(lv === exp_l, req, "read lanes", {28'h0, lv}, {28'h0, exp_l});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit ak; int lat, rl; logic [31:0] dv; logic [3:0] lv;
    rst_n = 0; idle_bus(); rd_wr = 1; siz = 0; addr = 0; data_in = 0; resp_delay = 0;
    repeat (4) @(negedge clk);
    check(dack_n == 2'b11 && lane_oe == 4'h0 && data_out == 32'h0, "R1", "outputs in reset",
          {dack_n, lane_oe, data_out[25:0]}, {2'b11, 30'h0});
    rst_n = 1;
    cmp_on = 1;
    repeat (4) @(negedge clk);
    check(dack_n == 2'b11 && lane_oe == 4'h0 && data_out == 32'h0, "R1", "outputs after reset",
          {dack_n, lane_oe, data_out[25:0]}, {2'b11, 30'h0});

    // long write, latency and release
    do_rw(1'b0, 16'h4000, 2'b00, 32'h11223344, 0, ak, lat, dv, lv, rl);
    check(ak, "R4", "write acknowledged", {31'h0, ak}, 32'h1);
    check(lv == 4'h0, "R4", "no lane driven on write", {28'h0, lv}, 32'h0);
    check(lat == 3, "R6", "zero-delay latency", lat, 3);
    check(rl == 2, "R7", "release after strobes drop", rl, 2);

    read_expect(16'h4000, 2'b00, 32'h11223344, 4'b1111, "R3");

    // byte write into lane 2 merges into the word
    do_rw(1'b0, 16'h4002, 2'b01, 32'h0000AB00, 0, ak, lat, dv, lv, rl);
    read_expect(16'h4000, 2'b00, 32'h1122AB44, 4'b1111, "R4");

    // size and offset combinations
    read_expect(16'h4001, 2'b01, 32'h00220000, 4'b0010, "R2");
    read_expect(16'h4002, 2'b10, 32'h0000AB44, 4'b1100, "R2");
    read_expect(16'h4001, 2'b11, 32'h0022AB44, 4'b1110, "R2");
    read_expect(16'h4003, 2'b00, 32'h00000044, 4'b1000, "R2");
    read_expect(16'h4003, 2'b10, 32'h00000044, 4'b1000, "R2");

    // programmable delay and acknowledge code
    do_rw(1'b1, 16'h4000, 2'b00, 32'h0, 5, ak, lat, dv, lv, rl);
    check(lat == 8, "R6", "five-clock delay latency", lat, 8);

    // write into a second word, then check the acknowledge pattern on it
    begin_cycle(1'b0, 16'h401C, 2'b00, 32'hA5A55A5A, 0, 1'b1, 30, ak, lat, dv, lv);
    check(dack_n == 2'b00, "R5", "32-bit acknowledge code", {30'h0, dack_n}, 32'h0);
    end_cycle(rl);
    read_expect(16'h401C, 2'b00, 32'hA5A55A5A, 4'b1111, "R4");

    // addresses outside the window
    begin_cycle(1'b0, 16'h5000, 2'b00, 32'hFFFFFFFF, 0, 1'b1, 20, ak, lat, dv, lv);
    check(!ak, "R9", "no ack outside window", {31'h0, ak}, 32'h0);
    end_cycle(rl);
    begin_cycle(1'b0, 16'h4020, 2'b00, 32'hFFFFFFFF, 0, 1'b1, 20, ak, lat, dv, lv);
    check(!ak, "R9", "no ack just past window", {31'h0, ak}, 32'h0);
    end_cycle(rl);
    read_expect(16'h4000, 2'b00, 32'h1122AB44, 4'b1111, "R9");

    // missing direction enable
    begin_cycle(1'b1, 16'h4000, 2'b00, 32'h0, 0, 1'b0, 20, ak, lat, dv, lv);
    check(!ak, "R11", "read without output enable", {31'h0, ak}, 32'h0);
    end_cycle(rl);
    begin_cycle(1'b0, 16'h4000, 2'b00, 32'h99999999, 0, 1'b0, 20, ak, lat, dv, lv);
    check(!ak, "R11", "write without write enable", {31'h0, ak}, 32'h0);
    end_cycle(rl);
    read_expect(16'h4000, 2'b00, 32'h1122AB44, 4'b1111, "R11");

    // abandoned write during the delay window
    begin_cycle(1'b0, 16'h4004, 2'b00, 32'hCAFEF00D, 12, 1'b1, 5, ak, lat, dv, lv);
    check(!ak, "R10", "no ack before abandon", {31'h0, ak}, 32'h0);
    idle_bus();
    ak = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dack_n != 2'b11) ak = 1;
    end
    check(!ak, "R10", "no ack after abandon", {31'h0, ak}, 32'h0);
    read_expect(16'h4004, 2'b00, 32'h00000000, 4'b1111, "R10");

    // release on output enable alone
    begin_cycle(1'b1, 16'h4000, 2'b00, 32'h0, 0, 1'b1, 30, ak, lat, dv, lv);
    repeat (4) @(negedge clk);
    check(dack_n == 2'b00 && data_out == 32'h1122AB44, "R7", "held while strobes stay",
          data_out, 32'h1122AB44);
    oe_n = 1;
    rl = -1;
    for (int i = 0; i < 10 && rl < 0; i++) begin
      @(negedge clk);
      if (dack_n == 2'b11) rl = i;
    end
    check(rl == 2, "R7", "release on output enable first", rl, 2);
    end_cycle(rl);

    // data strobe bounce while address strobe held
    begin_cycle(1'b1, 16'h4000, 2'b00, 32'h0, 0, 1'b1, 30, ak, lat, dv, lv);
    ds_n = 1;
    repeat (4) @(negedge clk);
    ds_n = 0;
    ak = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dack_n != 2'b11) ak = 1;
    end
    check(!ak, "R8", "no second ack without idle bus", {31'h0, ak}, 32'h0);
    end_cycle(rl);
    read_expect(16'h4001, 2'b10, 32'h0022AB00, 4'b0110, "R8");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule